// File: doc/BRIEF.md
# Fixed-Direction GPIO Port with Edge Interrupts

This block is a byte-wide GPIO port reached through a small register bus with an address, write data, read data, and separate read and write strobes. Four of its pins are permanent outputs and four are permanent inputs. Software sets the outputs and reads their values back. It samples the inputs through a two-stage synchroniser.

Each input has a 2-bit edge field in a configuration byte. The field selects falling edges, rising edges, both, or neither. A field of zero masks that input. An enabled edge sets a sticky status bit. Software clears a status bit by writing a 1 to it. The single interrupt request line stays high while any status bit is set.

Top module: `fdgpio_edge`

## Requirements
- R1: After reset, `pin_out` is 0, `irq` is 0, the configuration byte (offset 3) reads 0x00 and the status byte (offset 4) reads 0x00.
- R2: A read of offset 0 always returns 0x0F, where a 1 marks an output pin. Writes to offset 0 change no register and no pin.
- R3: A write to offset 1 loads bits [3:0] onto `pin_out`, and a read of offset 1 returns them in bits [3:0]. Bits [7:4] of a write are ignored. Bits [7:4] of a read return the levels of `pin_in[3:0]`, delayed by the two synchroniser stages.
- R4: The configuration byte at offset 3 reads back as written. Input k (k = 0..3) uses the field at bits [2k+1:2k]. In that field, bit 2k enables falling-edge detection and bit 2k+1 enables rising-edge detection.
- R5: A field of 11 detects both edges. A field of 00 masks the input, so no edge on it sets status.
- R6: An enabled edge on `pin_in[k]` sets status bit k, no later than the third rising clock edge after the pin changes. The bit stays set until it is cleared. Status bits [7:4] always read 0.
- R7: Writing offset 4 clears every status bit whose write-data bit is 1 and leaves the other bits unchanged.
- R8: `irq` is high exactly when at least one status bit is set.
- R9: If an edge on an input is detected in the same cycle that a clear of that input's status bit is written, the bit stays set.
- R10: Reads of offset 2 and of offsets 5 to 7 return 0, and writes to them have no effect. `rdata` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; `rdata` is valid in the same cycle |
| rdata | output | 8 | Read data |
| pin_out | output | 4 | Output pins |
| pin_in | input | 4 | Asynchronous input pins |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench goes after the cycle in which a clear collides with a newly detected edge on the same input. A design that lets the clear win would lose that edge, and the status bit would read 0 afterwards. It also drives edges against every field setting, including single-direction and masked fields. A design with the two field bits swapped, or one that ignores the mask, would set status on the wrong transitions. Partial clears, writes to the direction register, writes to the input half of the data byte, and accesses to the unused offsets are all checked. These show whether a design disturbs state that should not change, or fails to keep status bits sticky while `irq` stays high.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] OFF_DIR  = 3'd0;
  localparam logic [REG_AW-1:0] OFF_DATA = 3'd1;
  localparam logic [REG_AW-1:0] OFF_CFG  = 3'd3;
  localparam logic [REG_AW-1:0] OFF_STAT = 3'd4;

  // field bit 0: falling edge, field bit 1: rising edge
  function automatic logic edge_hit(input logic [1:0] mode, input logic prev, input logic cur);
    return (mode[0] & prev & ~cur) | (mode[1] & ~prev & cur);
  endfunction

  // a new hit has priority over a clear request
  function automatic logic flag_next(input logic flag, input logic hit, input logic clr);
    return hit | (flag & ~clr);
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d_async;
      s2_q <= s1_q;
    end
  end

  assign q_sync = s2_q;
endmodule

// File: rtl/gpio_edge_ch.sv
module gpio_edge_ch
  import gpio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_async,
  input  logic [1:0] mode,
  input  logic       clr,
  output logic       level,
  output logic       hit,
  output logic       flag
);
  logic prev_q;
  logic flag_q;

  gpio_sync2 u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_async),
    .q_sync  (level)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= level;
      flag_q <= flag_next(flag_q, hit, clr);
    end
  end

  assign hit  = edge_hit(mode, prev_q, level);
  assign flag = flag_q;
endmodule

// File: rtl/fdgpio_edge.sv
module fdgpio_edge
  import gpio_pkg::*;
#(
  parameter int N_OUT = 4,
  parameter int N_IN  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  output logic [N_OUT-1:0]  pin_out,
  input  logic [N_IN-1:0]   pin_in,
  output logic              irq
);
  localparam int DW    = N_OUT + N_IN;
  localparam int CFG_W = 2 * N_IN;

  logic [N_OUT-1:0] out_q;
  logic [CFG_W-1:0] cfg_q;
  logic [N_IN-1:0]  level_vec;
  logic [N_IN-1:0]  hit_vec;
  logic [N_IN-1:0]  status_q;
  logic [N_IN-1:0]  en_vec;
  logic [N_IN-1:0]  clr_vec;
  logic             wr_data, wr_cfg, wr_stat;

  assign wr_data = wr_en && (addr == OFF_DATA);
  assign wr_cfg  = wr_en && (addr == OFF_CFG);
  assign wr_stat = wr_en && (addr == OFF_STAT);
  assign clr_vec = wr_stat ? wdata[N_IN-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
      cfg_q <= '0;
    end else begin
      if (wr_data) out_q <= wdata[N_OUT-1:0];
      if (wr_cfg)  cfg_q <= wdata[CFG_W-1:0];
    end
  end

  for (genvar k = 0; k < N_IN; k++) begin : g_in
    gpio_edge_ch u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_async (pin_in[k]),
      .mode      (cfg_q[2*k+1:2*k]),
      .clr       (clr_vec[k]),
      .level     (level_vec[k]),
      .hit       (hit_vec[k]),
      .flag      (status_q[k])
    );
    assign en_vec[k] = |cfg_q[2*k+1:2*k];
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFF_DIR:  rdata[N_OUT-1:0] = '1;
        OFF_DATA: rdata[DW-1:0]    = {level_vec, out_q};
        OFF_CFG:  rdata[CFG_W-1:0] = cfg_q;
        OFF_STAT: rdata[N_IN-1:0]  = status_q;
        default:  rdata = '0;
      endcase
    end
  end

  assign pin_out = out_q;
  assign irq     = |status_q;
endmodule

// File: rtl/fdgpio_edge_chk.sv
module fdgpio_edge_chk
  import gpio_pkg::*;
#(
  parameter int N_OUT = 4,
  parameter int N_IN  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_AW-1:0] addr,
  input logic              wr_en,
  input logic [7:0]        wdata,
  input logic              rd_en,
  input logic [7:0]        rdata,
  input logic [N_OUT-1:0]  pin_out,
  input logic              irq,
  input logic [N_IN-1:0]   status_q,
  input logic [N_IN-1:0]   hit_vec,
  input logic [N_IN-1:0]   en_vec
);
  AST_DIR_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFF_DIR) |-> (rdata == 8'h0F)); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == OFF_DATA) |=> $stable(pin_out)); // R3
  AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |-> ((hit_vec & ~en_vec) == '0)); // R5
  AST_HIT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |=> ((status_q & $past(hit_vec)) == $past(hit_vec))); // R9
  AST_NO_SET_WITHOUT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(|hit_vec) |=> ((status_q & ~$past(status_q)) == '0)); // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == OFF_STAT) |=> ((status_q & $past(status_q)) == $past(status_q))); // R6
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_STAT) |=> ((status_q & $past(wdata[N_IN-1:0] & ~hit_vec)) == '0)); // R7
  AST_HIGH_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFF_STAT) |-> (rdata[7:4] == 4'h0)); // R6
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_en && addr == OFF_STAT)) |=> irq); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !(|hit_vec)) |=> !irq); // R8
endmodule

bind fdgpio_edge fdgpio_edge_chk #(.N_OUT(N_OUT), .N_IN(N_IN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .wr_en    (wr_en),
  .wdata    (wdata),
  .rd_en    (rd_en),
  .rdata    (rdata),
  .pin_out  (pin_out),
  .irq      (irq),
  .status_q (status_q),
  .hit_vec  (hit_vec),
  .en_vec   (en_vec)
);

// File: tb/tb_fdgpio_edge.sv
`timescale 1ns/1ps
module tb_fdgpio_edge;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;
  logic [3:0] pin_out;
  logic [3:0] pin_in = '0;
  logic       irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [3:0] m_out, m_in, m_stat;
  logic [7:0] m_cfg;

  always #2 clk = ~clk;

  fdgpio_edge dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .pin_out(pin_out), .pin_in(pin_in), .irq(irq)
  );

  // expected status bits set by a level change old -> nw under a config byte
  function automatic logic [3:0] exp_hits(input logic [7:0] cfg, input logic [3:0] old, input logic [3:0] nw);
    logic [3:0] r;
    for (int k = 0; k < 4; k++) begin
      logic up, dn;
      up = (old[k] == 1'b0) && (nw[k] == 1'b1);
      dn = (old[k] == 1'b1) && (nw[k] == 1'b0);
      r[k] = (up && cfg[2*k+1]) || (dn && cfg[2*k]);
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic set_pins(input logic [3:0] v);
    @(negedge clk);
    m_stat = m_stat | exp_hits(m_cfg, m_in, v);
    m_in = v;
    pin_in = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [7:0] d;
    rd(3'd1, d); chk({tag, " R3 data"}, d, {m_in, m_out});
    rd(3'd4, d); chk({tag, " R6 status"}, d, {4'h0, m_stat});
    chk({tag, " R8 irq"}, {7'd0, irq}, {7'd0, |m_stat});
    chk({tag, " R3 pin_out"}, {4'h0, pin_out}, {4'h0, m_out});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h00c0ffee));
    m_out = '0; m_in = '0; m_stat = '0; m_cfg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd3, d); chk("R1 cfg", d, 8'h00);
    rd(3'd4, d); chk("R1 status", d, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 pin_out", {4'h0, pin_out}, 8'h00);

    // R2 direction fixed
    rd(3'd0, d); chk("R2 dir", d, 8'h0F);
    wr(3'd0, 8'h00);
    rd(3'd0, d); chk("R2 dir after write", d, 8'h0F);
    chk("R2 pins untouched", {4'h0, pin_out}, 8'h00);

    // R3 data: upper write bits ignored
    wr(3'd1, 8'hF5); m_out = 4'h5;
    check_all("dir");
    set_pins(4'hA);
    check_all("inputs");

    // R10 unused offsets
    wr(3'd2, 8'hFF); wr(3'd5, 8'hFF); wr(3'd7, 8'hFF);
    rd(3'd2, d); chk("R10 off2", d, 8'h00);
    rd(3'd6, d); chk("R10 off6", d, 8'h00);
    check_all("R10 no effect");
    @(negedge clk); addr = 3'd0; #1 chk("R10 idle rdata", rdata, 8'h00);

    // R5 masked input
    set_pins(4'h5);
    check_all("R5 masked");

    // R4 field layout: input1 falling only (0x04)
    wr(3'd3, 8'h04); m_cfg = 8'h04;
    rd(3'd3, d); chk("R4 cfg readback", d, 8'h04);
    set_pins(4'h7);                // input1 rises: no status
    check_all("R4 rise ignored");
    set_pins(4'h5);                // input1 falls: status bit1
    check_all("R4 fall detected");
    chk("R4 bit1", {4'h0, m_stat}, 8'h02);

    // R5 both edges on input3 (0xC0)
    wr(3'd3, 8'hC0); m_cfg = 8'hC0;
    set_pins(4'hD);
    check_all("R5 both rise");
    wr(3'd4, 8'h08); m_stat &= ~4'h8;
    check_all("R7 clear bit3");
    set_pins(4'h5);
    check_all("R5 both fall");

    // R7 write 0 keeps bits
    wr(3'd4, 8'h00);
    check_all("R7 zero write");
    wr(3'd4, 8'hFF); m_stat = '0;
    check_all("R7 clear all");

    // R9 edge collides with clear of same bit (input0, both edges)
    wr(3'd3, 8'h03); m_cfg = 8'h03;
    set_pins(4'h4);                 // input0 falls -> bit0 set
    @(negedge clk); pin_in = 4'h5;  // rise on input0
    @(negedge clk);                 // after 1st stage
    @(negedge clk);                 // second stage loaded, hit pending
    addr = 3'd4; wdata = 8'h01; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    m_in = 4'h5; m_stat = 4'h1;
    repeat (3) @(negedge clk);
    check_all("R9 edge wins");
    wr(3'd4, 8'h01); m_stat = '0;
    check_all("R9 later clear");

    // random phase
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [7:0] v;
      op = $urandom_range(0, 3);
      v = 8'($urandom);
      case (op)
        0: begin wr(3'd1, v); m_out = v[3:0]; end
        1: begin wr(3'd3, v); m_cfg = v; end
        2: begin wr(3'd4, v); m_stat &= ~v[3:0]; end
        default: set_pins(v[3:0]);
      endcase
      if (i % 8 == 0) begin
        rd(3'd3, d); chk("R4 rand cfg", d, m_cfg);
      end
      check_all("rand");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule